// File: doc/BRIEF.md
# Variable-Frequency Rate Generator

This block turns a 16-bit control word into a square wave whose frequency is a fraction of the reference clock. It also produces a one-cycle tick strobe that a downstream constant-frequency PWM stage uses as its base rate. Each reference cycle, a 16-bit phase accumulator adds an effective increment W. The square wave is the accumulator's top bit, and the tick marks each cycle in which that bit goes from 0 to 1. The output frequency is W / 65536 times the reference clock, which is nominally 27 MHz.

W is derived from the control word. A word below 0x8000 is used as is. A word at or above 0x8000 is replaced by its 16-bit two's complement, so for example 0xF000 behaves like 0x1000 and 0x8000 stays 0x8000. Power-of-two increments give an exactly even high/low split. Words from 1 to 0x8000 are the useful range for clocking the PWM stage.

The word is loaded one byte at a time on a valid/ready configuration port. `cfg_hi` selects which half a beat carries. A high-byte beat only stages its byte. A low-byte beat commits the staged high byte together with its own byte as the new active word, so the active word never holds a half-updated value. `cfg_ready` is held at 1, so the block never applies back-pressure, and every cycle with `cfg_valid` high transfers one byte.

Top module: `rate_gen_top`

## Requirements
- R1: After reset `sq_out` and `tick` are 0, the staged high byte and the active word are 0, and no ticks occur until a word is committed.
- R2: Each reference cycle the accumulator advances by W, and `sq_out` shows its bit 15 one clock after the edge. For a word that W divides into 65536, there are exactly 65536/W cycles per tick (0x1000 gives 16 ticks in 256 cycles).
- R3: A word with bit 15 set is folded to 65536 minus the word before it is added (0xF000 gives 16 ticks in 256 cycles, and 0x8000 gives one tick every 2 cycles).
- R4: A beat with `cfg_hi`=1 only stages `cfg_data`, and the output frequency is unchanged afterwards.
- R5: A beat with `cfg_hi`=0 makes {staged high byte, `cfg_data`} the active word at that clock edge, and the new W is used from the next edge on.
- R6: `tick` is 1 for exactly those cycles in which `sq_out` has just changed from 0 to 1.
- R7: A power-of-two W gives equal numbers of high and low cycles on `sq_out` (0x1000 gives 128 high cycles out of 256).
- R8: An active word of 0 freezes the accumulator: `sq_out` stays constant and `tick` stays 0.
- R9: `cfg_ready` is always 1, and every `cfg_valid` cycle transfers one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration byte present |
| cfg_ready | output | 1 | Always 1; the port never stalls |
| cfg_hi | input | 1 | 1: stage the high byte; 0: the low byte, which commits the word |
| cfg_data | input | 8 | Byte value |
| sq_out | output | 1 | Variable-frequency square wave (accumulator bit 15) |
| tick | output | 1 | One-cycle strobe on each rising edge of `sq_out` |

## Verification
The two functions that can fall in the same cycle are a low-byte commit and an accumulator step that raises bit 15. The step at that edge must still use the old increment, and the new one applies only from the following edge. The bench provokes this by committing words at arbitrary phases of a running wave, for example by switching straight to 0x8000, which ticks every other cycle.

A cycle-accurate scoreboard model judges every cycle's `sq_out` and `tick`. It also counts ticks and high cycles over whole-period windows after each change of word.

// File: rtl/rate_gen_pkg.sv
package rate_gen_pkg;
  localparam int unsigned RG_WORD_W = 16;
  localparam int unsigned RG_BYTE_W = 8;

  typedef enum logic {
    LANE_LO = 1'b0,
    LANE_HI = 1'b1
  } lane_e;
endpackage

// File: rtl/rate_gen_cword.sv
module rate_gen_cword #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] stage_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned HI_W = WORD_W - BYTE_W;

  logic [HI_W-1:0] stage_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      word_q  <= '0;
    end else if (wr_en) begin
      if (wr_hi == rate_gen_pkg::LANE_HI) stage_q <= wr_data[HI_W-1:0];
      else                                word_q  <= {stage_q, wr_data};
    end
  end

  assign stage_o = BYTE_W'(stage_q);
  assign word_o  = word_q;
endmodule

// File: rtl/rate_gen_fold.sv
module rate_gen_fold #(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] inc_o
);
  localparam int unsigned TOP = WORD_W - 1;

  always_comb begin
    if (word_i[TOP]) inc_o = (~word_i) + WORD_W'(1);
    else             inc_o = word_i;
  end
endmodule

// File: rtl/rate_gen_accum.sv
module rate_gen_accum #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] inc_i,
  output logic [WORD_W-1:0] acc_o,
  output logic              sq_o,
  output logic              tick_o
);
  localparam int unsigned TOP = WORD_W - 1;

  logic [WORD_W-1:0] acc_q, acc_d;
  logic              tick_q;

  assign acc_d = acc_q + inc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= acc_d[TOP] & ~acc_q[TOP];
    end
  end

  assign acc_o  = acc_q;
  assign sq_o   = acc_q[TOP];
  assign tick_o = tick_q;
endmodule

// File: rtl/rate_gen_top.sv
module rate_gen_top #(
  parameter int unsigned WORD_W = rate_gen_pkg::RG_WORD_W,
  parameter int unsigned BYTE_W = rate_gen_pkg::RG_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic              cfg_hi,
  input  logic [BYTE_W-1:0] cfg_data,
  output logic              sq_out,
  output logic              tick
);
  logic [WORD_W-1:0] cw_active;
  logic [BYTE_W-1:0] cw_stage;
  logic [WORD_W-1:0] inc_w;
  logic [WORD_W-1:0] acc_val;

  assign cfg_ready = 1'b1;

  rate_gen_cword #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_cword (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_valid & cfg_ready),
    .wr_hi   (cfg_hi),
    .wr_data (cfg_data),
    .stage_o (cw_stage),
    .word_o  (cw_active)
  );

  rate_gen_fold #(.WORD_W(WORD_W)) u_fold (
    .word_i (cw_active),
    .inc_o  (inc_w)
  );

  rate_gen_accum #(.WORD_W(WORD_W)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (inc_w),
    .acc_o  (acc_val),
    .sq_o   (sq_out),
    .tick_o (tick)
  );
endmodule

// File: rtl/rate_gen_chk.sv
module rate_gen_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_valid,
  input logic              cfg_hi,
  input logic [BYTE_W-1:0] cfg_data,
  input logic [BYTE_W-1:0] stage,
  input logic [WORD_W-1:0] word,
  input logic [WORD_W-1:0] acc,
  input logic              sq,
  input logic              tick
);
  // R6
  tick_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (sq && !$past(sq)));

  // R6
  rise_has_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sq && !$past(sq)) |-> tick);

  // R4
  hi_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_hi) |=> $stable(word));

  // R5
  lo_write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_hi) |=> (word == {$past(stage[WORD_W-BYTE_W-1:0]), $past(cfg_data)}));

  // R8
  zero_word_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word == '0 && !(cfg_valid && !cfg_hi)) |=> ($stable(acc) && !tick));
endmodule

bind rate_gen_top rate_gen_chk #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_valid (cfg_valid),
  .cfg_hi    (cfg_hi),
  .cfg_data  (cfg_data),
  .stage     (cw_stage),
  .word      (cw_active),
  .acc       (acc_val),
  .sq        (sq_out),
  .tick      (tick)
);

// File: tb/test_rate_gen_top.sv
`timescale 1ns/1ps
module test_rate_gen_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic       cfg_hi = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       cfg_ready, sq_out, tick;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rate_gen_top i_rate_gen_top (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_hi(cfg_hi), .cfg_data(cfg_data), .sq_out(sq_out), .tick(tick)
  );

  // expected {sq, tick} per cycle
  logic [1:0]  exp_q[$];
  logic [15:0] m_acc = '0;
  logic [15:0] m_word = '0;
  logic [7:0]  m_stage = '0;

  function automatic logic [15:0] step_of(input logic [15:0] c);
    logic [16:0] t;
    t = 17'h10000 - {1'b0, c};
    return c[15] ? t[15:0] : c;   // R3 fold
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: pushes the expected outputs after each edge
  always @(posedge clk) begin
    logic [15:0] nxt;
    if (!rst_n) begin
      m_acc = '0; m_word = '0; m_stage = '0;
      exp_q.push_back(2'b00);
    end else begin
      nxt = m_acc + step_of(m_word);
      exp_q.push_back({nxt[15], nxt[15] & ~m_acc[15]});
      m_acc = nxt;
      if (cfg_valid) begin
        if (cfg_hi) m_stage = cfg_data;
        else        m_word = {m_stage, cfg_data};
      end
    end
  end

  // monitor: compares away from the active edge (R2 R5 R6)
  always @(negedge clk) begin
    logic [1:0] e;
    if (!done && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check("R2/R5/R6 sq_out", int'(sq_out), int'(e[1]));
      check("R6 tick", int'(tick), int'(e[0]));
    end
  end

  task automatic send(input logic hi, input logic [7:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_hi = hi; cfg_data = d;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic load(input logic [15:0] w);
    send(1'b1, w[15:8]);
    send(1'b0, w[7:0]);
  endtask

  task automatic window(input int n, output int ticks, output int highs);
    ticks = 0; highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ticks += int'(tick);
      highs += int'(sq_out);
    end
  endtask

  initial begin
    int t, h;
    repeat (3) @(negedge clk);
    check("R1 sq_out reset", int'(sq_out), 0);
    check("R1 tick reset", int'(tick), 0);
    check("R9 ready", int'(cfg_ready), 1);
    rst_n = 1'b1;
    window(64, t, h);
    check("R1 no ticks before word", t, 0);

    load(16'h1000);
    window(256, t, h);
    check("R2 ticks for 0x1000", t, 16);
    check("R7 high cycles for 0x1000", h, 128);

    send(1'b1, 8'h20);                 // high byte only
    window(256, t, h);
    check("R4 staged high byte leaves rate", t, 16);
    send(1'b0, 8'h00);                 // commits 0x2000
    window(256, t, h);
    check("R5 ticks after commit 0x2000", t, 32);
    check("R7 high cycles for 0x2000", h, 128);

    load(16'hF000);
    window(256, t, h);
    check("R3 folded 0xF000 ticks", t, 16);

    load(16'h8000);
    window(256, t, h);
    check("R3 0x8000 ticks", t, 128);
    check("R7 0x8000 high cycles", h, 128);

    load(16'h0000);
    window(200, t, h);
    check("R8 zero word ticks", t, 0);
    check("R8 zero word level constant", int'(h == 0 || h == 200), 1);

    load(16'h0400);
    window(1024, t, h);
    check("R2 ticks for 0x0400", t, 16);
    check("R9 ready stays high", int'(cfg_ready), 1);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule